// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block resolves eight interrupt request lines into one interrupt output. Each line is captured into a request register. Every line has its own capture rule, which is either on a rising edge or by following the level. A mask register hides lines from arbitration. The best unmasked pending request is compared with the best line that is already in service, and both searches start from a programmable rotating base. The output is raised only when the pending request outranks the in-service one. The result is presented as a granted line number with a valid flag.

The host acknowledges a grant with a one-cycle strobe that carries the line number. A command port writes the mask, the capture-select register and the mode bits. The same port issues end-of-service commands, which can be specific or highest-first and can optionally rotate the base, and it can set the base directly. All internal registers are brought out for readback. Bus decoding and chaining of several resolvers are left to the surrounding logic. The in-service comparison can hide masked lines or, on a master, the cascade line, so that nesting behaves as the system needs.

Top module: `prio_irq_top`

## Requirements
- R1: Line (k + base) mod 8 has priority k, and 0 is the highest. A set with no bits ranks below every line. With no unmasked pending request, `intOut` is 0.
- R2: `grantValid` and `intOut` are 1 only when the best unmasked pending priority is strictly higher than the best in-service priority. `grantLine` is (priority + base) mod 8. The grant is combinational from registered state.
- R3: With mode bit 2 (special mask) set, in-service lines that are masked are left out of the in-service priority.
- R4: With mode bit 3 (cascade nesting) set on a master (`IS_MASTER`=1), in-service bit `CASCADE_LINE` (2) is left out of the in-service priority.
- R5: An edge-captured line sets its request bit one clock after its input goes from 0 to 1. A line held high does not set it again.
- R6: For a level-captured line, the request bit equals the input level sampled at the previous clock.
- R7: `ackStrobe` with mode bit 0 (auto end) clear sets the in-service bit of `ackLine`. It clears the request bit of that line only if the line is edge-captured.
- R8: With auto end set, an acknowledge sets no in-service bit. If mode bit 1 (rotate on auto end) is also set, the base becomes (`ackLine` + 1) mod 8.
- R9: An acknowledge and a rising edge on the same edge-captured line in the same cycle leave the request bit clear.
- R10: Op 4 clears the highest-priority in-service bit, and op 5 does the same and also sets the base to (that line + 1) mod 8. Op 6 clears in-service bit `cmdData[2:0]`, and op 7 does the same and also sets the base to (that line + 1) mod 8. Op 8 sets the base to (`cmdData[2:0]` + 1) mod 8.
- R11: Reset clears the request, in-service, mask and capture-select registers, the base and all mode bits, so every line is edge-captured.
- R12: Op 1 writes the mask from `cmdData`, op 2 writes the capture-select register (1 means level), and op 3 writes the mode from `cmdData[3:0]`. Op 0 and ops 9 to 15 do nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqIn | input | 8 | Interrupt request inputs |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 4 | Command opcode |
| cmdData | input | 8 | Command operand |
| ackStrobe | input | 1 | One-cycle acknowledge |
| ackLine | input | 3 | Line being acknowledged |
| intOut | output | 1 | Interrupt output |
| grantValid | output | 1 | Granted line is valid |
| grantLine | output | 3 | Granted line number |
| irrOut | output | 8 | Request register |
| isrOut | output | 8 | In-service register |
| imrOut | output | 8 | Mask register |
| trigOut | output | 8 | Capture select, 1 = level |
| baseOut | output | 3 | Rotating priority base |

## Verification
Any input change, command or acknowledge takes effect at the next rising clock edge, when the registers update. The grant and the interrupt output then follow combinationally with no further cycle. The bench therefore holds each stimulus until exactly one edge has passed and samples every output one nanosecond later. All readback registers are checked at that same point. Hold behaviour, such as no retrigger while an edge-captured line stays high, is checked over several following single-edge steps.

// File: rtl/prio_irq_pkg.sv
`timescale 1ns/1ps
package prio_irq_pkg;
  localparam int LINES = 8;
  localparam int IDW = $clog2(LINES);
  localparam int OPW = 4;

  typedef logic [LINES-1:0] vec_t;
  typedef logic [IDW-1:0] line_t;
  typedef logic [IDW:0] prio_t;

  typedef enum logic [OPW-1:0] {
    OP_NOP          = 4'd0,
    OP_MASK         = 4'd1,
    OP_TRIG         = 4'd2,
    OP_MODE         = 4'd3,
    OP_EOI_TOP      = 4'd4,
    OP_EOI_TOP_ROT  = 4'd5,
    OP_EOI_LINE     = 4'd6,
    OP_EOI_LINE_ROT = 4'd7,
    OP_SET_LOWEST   = 4'd8
  } cmd_op_e;

  typedef struct packed {
    logic nestedCascade;
    logic specialMask;
    logic rotAutoEoi;
    logic autoEoi;
  } mode_t;

  typedef struct packed {
    logic  wrMask;
    logic  wrTrig;
    logic  eoiTop;
    logic  eoiLine;
    logic  rotAfterEoi;
    logic  setLowest;
    logic  ack;
    line_t ackLine;
    line_t cmdLine;
    vec_t  cmdVal;
  } strobe_t;

  // Rank of the best set bit, searching from base; LINES when empty.
  function automatic prio_t prio_of(input vec_t m, input line_t base);
    prio_t r;
    r = prio_t'(LINES);
    for (int k = LINES - 1; k >= 0; k--) begin
      if (m[line_t'(k) + base]) r = prio_t'(k);
    end
    return r;
  endfunction
endpackage

// File: rtl/prio_irq_ctrl.sv
`timescale 1ns/1ps
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [OPW-1:0]  cmdOp,
  input  vec_t            cmdData,
  input  logic            ackStrobe,
  input  line_t           ackLine,
  output strobe_t         stb,
  output mode_t           mode
);
  cmd_op_e op;
  assign op = cmd_op_e'(cmdOp);

  always_comb begin
    stb         = '0;
    stb.ack     = ackStrobe;
    stb.ackLine = ackLine;
    stb.cmdLine = cmdData[IDW-1:0];
    stb.cmdVal  = cmdData;
    if (cmdValid) begin
      case (op)
        OP_MASK:         stb.wrMask = 1'b1;
        OP_TRIG:         stb.wrTrig = 1'b1;
        OP_EOI_TOP:      stb.eoiTop = 1'b1;
        OP_EOI_TOP_ROT:  begin stb.eoiTop = 1'b1; stb.rotAfterEoi = 1'b1; end
        OP_EOI_LINE:     stb.eoiLine = 1'b1;
        OP_EOI_LINE_ROT: begin stb.eoiLine = 1'b1; stb.rotAfterEoi = 1'b1; end
        OP_SET_LOWEST:   stb.setLowest = 1'b1;
        default:         ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode <= '0;
    end else if (cmdValid && op == OP_MODE) begin
      mode.autoEoi       <= cmdData[0];
      mode.rotAutoEoi    <= cmdData[1];
      mode.specialMask   <= cmdData[2];
      mode.nestedCascade <= cmdData[3];
    end
  end
endmodule

// File: rtl/prio_irq_dp.sv
`timescale 1ns/1ps
module prio_irq_dp
  import prio_irq_pkg::*;
#(
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  vec_t    irqIn,
  input  strobe_t stb,
  input  mode_t   mode,
  output logic    grantValid,
  output line_t   grantLine,
  output vec_t    irr,
  output vec_t    isr,
  output vec_t    imr,
  output vec_t    trig,
  output line_t   base
);
  vec_t  lastLvl;
  vec_t  irrNext;
  vec_t  isrNext;
  line_t baseNext;
  vec_t  ackHit;
  vec_t  curMask;
  prio_t pendPrio;
  prio_t curPrio;
  prio_t topPrio;
  line_t topLine;
  logic  isrAny;

  // Arbitration, purely from registered state
  always_comb begin
    curMask = isr;
    if (mode.specialMask) curMask = curMask & ~imr;
    if (IS_MASTER && mode.nestedCascade) curMask[CASCADE_LINE] = 1'b0;
  end

  assign pendPrio   = prio_of(irr & ~imr, base);
  assign curPrio    = prio_of(curMask, base);
  assign grantValid = pendPrio < curPrio;
  assign grantLine  = pendPrio[IDW-1:0] + base;

  assign topPrio = prio_of(isr, base);
  assign isrAny  = !topPrio[IDW];
  assign topLine = topPrio[IDW-1:0] + base;

  assign ackHit = stb.ack ? (vec_t'(1) << stb.ackLine) : '0;

  // Per-line capture cells
  for (genvar g = 0; g < LINES; g++) begin : gCapture
    assign irrNext[g] = trig[g] ? irqIn[g]
                                : ((irr[g] | (irqIn[g] & ~lastLvl[g])) & ~ackHit[g]);
  end

  always_comb begin
    isrNext  = isr;
    baseNext = base;
    if (stb.ack) begin
      if (!mode.autoEoi) isrNext[stb.ackLine] = 1'b1;
      else if (mode.rotAutoEoi) baseNext = stb.ackLine + line_t'(1);
    end
    if (stb.eoiTop && isrAny) begin
      isrNext[topLine] = 1'b0;
      if (stb.rotAfterEoi) baseNext = topLine + line_t'(1);
    end
    if (stb.eoiLine) begin
      isrNext[stb.cmdLine] = 1'b0;
      if (stb.rotAfterEoi) baseNext = stb.cmdLine + line_t'(1);
    end
    if (stb.setLowest) baseNext = stb.cmdLine + line_t'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr     <= '0;
      isr     <= '0;
      imr     <= '0;
      trig    <= '0;
      base    <= '0;
      lastLvl <= '0;
    end else begin
      irr     <= irrNext;
      isr     <= isrNext;
      base    <= baseNext;
      lastLvl <= irqIn;
      if (stb.wrMask) imr  <= stb.cmdVal;
      if (stb.wrTrig) trig <= stb.cmdVal;
    end
  end
endmodule

// File: rtl/prio_irq_top.sv
`timescale 1ns/1ps
module prio_irq_top
  import prio_irq_pkg::*;
#(
  parameter bit IS_MASTER    = 1'b1,
  parameter int CASCADE_LINE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [LINES-1:0] irqIn,
  input  logic             cmdValid,
  input  logic [OPW-1:0]   cmdOp,
  input  logic [LINES-1:0] cmdData,
  input  logic             ackStrobe,
  input  logic [IDW-1:0]   ackLine,
  output logic             intOut,
  output logic             grantValid,
  output logic [IDW-1:0]   grantLine,
  output logic [LINES-1:0] irrOut,
  output logic [LINES-1:0] isrOut,
  output logic [LINES-1:0] imrOut,
  output logic [LINES-1:0] trigOut,
  output logic [IDW-1:0]   baseOut
);
  strobe_t stb;
  mode_t   modeQ;

  prio_irq_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdData(cmdData), .ackStrobe(ackStrobe), .ackLine(ackLine),
    .stb(stb), .mode(modeQ)
  );

  prio_irq_dp #(.IS_MASTER(IS_MASTER), .CASCADE_LINE(CASCADE_LINE)) dp_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .stb(stb), .mode(modeQ),
    .grantValid(grantValid), .grantLine(grantLine), .irr(irrOut),
    .isr(isrOut), .imr(imrOut), .trig(trigOut), .base(baseOut)
  );

  assign intOut = grantValid;
endmodule

// File: rtl/prio_irq_chk.sv
`timescale 1ns/1ps
module prio_irq_chk
  import prio_irq_pkg::*;
(
  input logic  clk,
  input logic  rstN,
  input vec_t  irqIn,
  input logic  ackStrobe,
  input line_t ackLine,
  input logic  cmdValid,
  input logic  intOut,
  input logic  grantValid,
  input line_t grantLine,
  input vec_t  irrOut,
  input vec_t  imrOut,
  input vec_t  isrOut,
  input vec_t  trigOut,
  input line_t baseOut,
  input logic  autoEoi,
  input logic  rotAutoEoi
);
  assert_idle_no_int_R1: assert property (@(posedge clk) disable iff (!rstN)
    ((irrOut & ~imrOut) == '0) |-> !intOut);

  assert_grant_pending_R2: assert property (@(posedge clk) disable iff (!rstN)
    grantValid |-> (irrOut[grantLine] && !imrOut[grantLine]));

  assert_level_follow_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((irrOut ^ $past(irqIn)) & $past(trigOut)) == '0);

  assert_ack_sets_isr_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !autoEoi && !cmdValid) |=> isrOut[$past(ackLine)]);

  assert_auto_rotate_R8: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && autoEoi && rotAutoEoi && !cmdValid) |=>
      (baseOut == line_t'($past(ackLine) + line_t'(1))));

  assert_ack_beats_edge_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ackStrobe && !trigOut[ackLine]) |=> !irrOut[$past(ackLine)]);
endmodule

bind prio_irq_top prio_irq_chk chk_i (
  .clk(clk), .rstN(rstN), .irqIn(irqIn), .ackStrobe(ackStrobe),
  .ackLine(ackLine), .cmdValid(cmdValid), .intOut(intOut),
  .grantValid(grantValid), .grantLine(grantLine), .irrOut(irrOut),
  .imrOut(imrOut), .isrOut(isrOut), .trigOut(trigOut), .baseOut(baseOut),
  .autoEoi(modeQ.autoEoi), .rotAutoEoi(modeQ.rotAutoEoi)
);

// File: tb/prio_irq_top_tb_top.sv
`timescale 1ns/1ps
module prio_irq_top_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] irqIn = '0;
  logic       cmdValid = 1'b0;
  logic [3:0] cmdOp = '0;
  logic [7:0] cmdData = '0;
  logic       ackStrobe = 1'b0;
  logic [2:0] ackLine = '0;
  logic       intOut, grantValid;
  logic [2:0] grantLine, baseOut;
  logic [7:0] irrOut, isrOut, imrOut, trigOut;

  int totalCnt = 0;
  int failCnt = 0;

  always #2 clk = ~clk;

  prio_irq_top dut_i (
    .clk(clk), .rstN(rstN), .irqIn(irqIn), .cmdValid(cmdValid),
    .cmdOp(cmdOp), .cmdData(cmdData), .ackStrobe(ackStrobe),
    .ackLine(ackLine), .intOut(intOut), .grantValid(grantValid),
    .grantLine(grantLine), .irrOut(irrOut), .isrOut(isrOut),
    .imrOut(imrOut), .trigOut(trigOut), .baseOut(baseOut)
  );

  typedef struct packed {
    logic [3:0] op;
    logic [7:0] data;
    logic [7:0] irq;
    logic       ack;
    logic [2:0] line;
    logic       expValid;
    logic [2:0] expLine;
    logic [7:0] expIsr;
    logic [2:0] expBase;
  } row_t;

  localparam int NROWS = 11;
  localparam row_t ROWS [NROWS] = '{
    '{4'd0, 8'h00, 8'h00, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 3'd0},
    '{4'd0, 8'h00, 8'h28, 1'b0, 3'd0, 1'b1, 3'd3, 8'h00, 3'd0},
    '{4'd0, 8'h00, 8'h28, 1'b1, 3'd3, 1'b0, 3'd0, 8'h08, 3'd0},
    '{4'd4, 8'h00, 8'h28, 1'b0, 3'd0, 1'b1, 3'd5, 8'h00, 3'd0},
    '{4'd0, 8'h00, 8'h28, 1'b1, 3'd5, 1'b0, 3'd0, 8'h20, 3'd0},
    '{4'd0, 8'h00, 8'h29, 1'b0, 3'd0, 1'b1, 3'd0, 8'h20, 3'd0},
    '{4'd1, 8'h01, 8'h29, 1'b0, 3'd0, 1'b0, 3'd0, 8'h20, 3'd0},
    '{4'd7, 8'h05, 8'h29, 1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 3'd6},
    '{4'd1, 8'h00, 8'h29, 1'b0, 3'd0, 1'b1, 3'd0, 8'h00, 3'd6},
    '{4'd8, 8'h00, 8'h29, 1'b0, 3'd0, 1'b1, 3'd0, 8'h00, 3'd1},
    '{4'd0, 8'h00, 8'h2D, 1'b0, 3'd0, 1'b1, 3'd2, 8'h00, 3'd1}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    totalCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    cmdValid  = 1'b0;
    ackStrobe = 1'b0;
  endtask

  task automatic issue(input logic [3:0] op, input logic [7:0] data);
    cmdOp = op; cmdData = data; cmdValid = 1'b1;
  endtask

  task automatic acknowledge(input logic [2:0] line);
    ackLine = line; ackStrobe = 1'b1;
  endtask

  task automatic doReset();
    rstN = 1'b0; irqIn = '0; cmdValid = 1'b0; ackStrobe = 1'b0;
    step(); step();
    rstN = 1'b1;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", totalCnt - failCnt, totalCnt);
  endtask

  initial begin
    #800000;
    failCnt++; totalCnt++;
    $display("FAIL watchdog actual=running expected=done");
    summary();
    $finish;
  end

  initial begin
    doReset();
    // R11: reset state
    check("R11 irr", irrOut, 0);
    check("R11 isr", isrOut, 0);
    check("R11 int", intOut, 0);

    // Table walk: R1 R2 R5 R7 R10 R12
    for (int i = 0; i < NROWS; i++) begin
      issue(ROWS[i].op, ROWS[i].data);
      cmdValid = (ROWS[i].op != 4'd0);
      irqIn = ROWS[i].irq;
      if (ROWS[i].ack) acknowledge(ROWS[i].line);
      step();
      check($sformatf("R2 row %0d valid", i), grantValid, ROWS[i].expValid);
      if (ROWS[i].expValid)
        check($sformatf("R1 row %0d line", i), grantLine, ROWS[i].expLine);
      check($sformatf("R7 row %0d isr", i), isrOut, ROWS[i].expIsr);
      check($sformatf("R10 row %0d base", i), baseOut, ROWS[i].expBase);
    end

    // R11 / R12: registers written, then cleared by reset
    issue(4'd1, 8'hF0); step();
    check("R12 mask readback", imrOut, 8'hF0);
    issue(4'd2, 8'h0F); step();
    check("R12 trig readback", trigOut, 8'h0F);
    issue(4'd12, 8'hFF); step();
    check("R12 unused op", {imrOut, trigOut}, 16'hF00F);
    doReset();
    check("R11 mask cleared", imrOut, 0);
    check("R11 trig cleared", trigOut, 0);
    check("R11 base cleared", baseOut, 0);

    // R6 / R7: level capture
    issue(4'd2, 8'h10); step();
    irqIn = 8'h10; step();
    check("R6 level sets irr", irrOut, 8'h10);
    check("R6 grant line", grantLine, 3'd4);
    acknowledge(3'd4); step();
    check("R7 level irr kept", irrOut, 8'h10);
    check("R7 isr set", isrOut, 8'h10);
    irqIn = 8'h00; step();
    check("R6 level follows low", irrOut, 8'h00);

    // R9 / R5: ack beats same-cycle edge, no retrigger while held
    doReset();
    irqIn = 8'h40; acknowledge(3'd6); step();
    check("R9 ack beats edge", irrOut, 8'h00);
    step();
    check("R5 held high no retrigger", irrOut, 8'h00);
    irqIn = 8'h00; step();
    irqIn = 8'h40; step();
    check("R5 new edge", irrOut, 8'h40);

    // R8: auto end with rotation
    doReset();
    issue(4'd3, 8'h03); step();
    irqIn = 8'h02; step();
    acknowledge(3'd1); step();
    check("R8 no isr", isrOut, 8'h00);
    check("R8 base rotated", baseOut, 3'd2);
    check("R8 irr cleared", irrOut, 8'h00);

    // R3: special mask
    doReset();
    irqIn = 8'h08; step();
    acknowledge(3'd3); step();
    irqIn = 8'h28; step();
    check("R2 lower pending blocked", intOut, 1'b0);
    issue(4'd1, 8'h08); step();
    check("R3 mask alone blocked", intOut, 1'b0);
    issue(4'd3, 8'h04); step();
    check("R3 special mask grants", {intOut, grantLine}, {1'b1, 3'd5});

    // R4: cascade nesting on master
    doReset();
    irqIn = 8'h04; step();
    acknowledge(3'd2); step();
    irqIn = 8'h00; step();
    irqIn = 8'h04; step();
    check("R4 same line blocked", intOut, 1'b0);
    issue(4'd3, 8'h08); step();
    check("R4 cascade nested grant", {intOut, grantLine}, {1'b1, 3'd2});

    // R10 / R1: rotation and highest-first end
    doReset();
    irqIn = 8'h81; step();
    check("R1 base0 picks line0", grantLine, 3'd0);
    acknowledge(3'd0); step();
    check("R2 line7 blocked", intOut, 1'b0);
    issue(4'd8, 8'h06); step();
    check("R1 base7 grants line7", {intOut, grantLine, baseOut}, {1'b1, 3'd7, 3'd7});
    acknowledge(3'd7); step();
    issue(4'd5, 8'h00); step();
    check("R10 top end rotates", {isrOut, baseOut}, {8'h01, 3'd0});

    summary();
    $finish;
  end
endmodule